// File: doc/BRIEF.md
# Manchester Line Encoder Transmitter

This block turns a serial stream of NRZ bits into a self-clocking Manchester waveform for a 10 Mb/s link. It runs on a single clock at twice the bit rate, 20 MHz nominally, so every 100 ns bit cell is split into two half-cell phases. Bits arrive on a valid/ready stream. The line is a logical pair `tx_p`/`tx_n`: a high level drives `tx_p=1, tx_n=0` and a low level drives `tx_p=0, tx_n=1`.

Back-pressure comes only from the encoder. Once a frame has started, the line timing is fixed. `tx_ready` rises once per cell, in its second half, and a source that wants to continue must already present the next bit with `tx_valid` high. If `tx_valid` is low when `tx_ready` is high inside a frame, the frame closes. The line then stays high for a short tail before it returns to its idle level, so the frame always ends on a rising edge. That edge falls mid-cell when the final bit is a one, and on the cell boundary when the final bit is a zero.

`idle_eq` selects the idle level of the pair. When it is low, the idle pair is driven differential with `tx_p` high. When it is high, both wires sit low, which suits transformer-coupled loads. `loop_en` holds the pair idle but leaves the encoded stream running on `enc_o`, so a receive path can take it internally.

Top module: `mle_tx`

## Requirements
- R1: During reset and after it, with no traffic, `tx_ready` is 1, `enc_o` is 1 and the pair is at the idle level chosen by `idle_eq`.
- R2: A bit is taken on a rising clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 1 while idle and during the second half of every cell. It is 0 during the first half of every cell.
- R3: A one is sent as low then high, and a zero as high then low. If a bit is taken at edge h, its first half is visible on the outputs after edge h+1 and its second half after edge h+2.
- R4: A frame ends when `tx_valid` is 0 while `tx_ready` is 1 inside a frame. The last edge on the line is then rising: at mid-cell when the final bit is a one, and at the cell boundary when the final bit is a zero.
- R5: After the final cell, the line is held high for TAIL_HALVES half cells, with `tx_ready` at 0, and then goes idle.
- R6: With `idle_eq` = 0, the idle pair is `tx_p=1, tx_n=0`.
- R7: With `idle_eq` = 1, the idle pair is `tx_p=0, tx_n=0`.
- R8: While `loop_en` is 1, the pair stays at its idle level and `tx_ready`/`enc_o` behave exactly as without loopback.
- R9: `enc_o` carries the same level sequence as the pair, and is 1 when idle.
- R10: `tx_p` and `tx_n` are never both 1.
- R11: A request raised during the tail waits for it to end. If the previous frame's last bit was taken at edge h, the next frame's first bit is taken at edge h+3+TAIL_HALVES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Source has a bit; low at a ready slot ends the frame |
| tx_data | input | 1 | NRZ bit offered |
| tx_ready | output | 1 | Encoder takes a bit at this edge if valid |
| idle_eq | input | 1 | Idle mode: 0 driven differential, 1 equal levels |
| loop_en | input | 1 | Hold pair idle; encoded stream stays on enc_o |
| tx_p | output | 1 | Line pair, positive wire |
| tx_n | output | 1 | Line pair, negative wire |
| enc_o | output | 1 | Encoded level stream for internal loopback |

## Verification
The end of one frame and the request for the next can meet in the same cycle. The bench raises `tx_valid` again right after the final bit, while the tail is still running. It judges the overlap by the edge at which the new first bit is taken, and by confirming that the old frame's rising close and single idle half-cell come out intact. Loopback and frame encoding also act together: a frame sent under `loop_en` must show the full waveform on `enc_o` while the pair does not move.

// File: rtl/mle_pkg.sv
package mle_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CELL = 2'd1,
    ST_TAIL = 2'd2
  } mle_state_e;

  localparam logic LVL_HIGH = 1'b1;
endpackage

// File: rtl/mle_seq.sv
module mle_seq
  import mle_pkg::*;
#(
  parameter int TAIL_HALVES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_valid,
  input  logic       tx_data,
  output logic       tx_ready,
  output logic       line_lvl,
  output logic       line_idle,
  output mle_state_e state_o,
  output logic       phase_o
);
  localparam int CW = (TAIL_HALVES < 2) ? 1 : $clog2(TAIL_HALVES);
  localparam logic [CW-1:0] CNT_LAST = CW'(TAIL_HALVES - 1);

  mle_state_e    st_q;
  logic          ph_q;
  logic          bit_q;
  logic [CW-1:0] cnt_q;
  logic          take;

  assign tx_ready = (st_q == ST_IDLE) || (st_q == ST_CELL && ph_q);
  assign take     = tx_ready && tx_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ph_q  <= 1'b0;
      bit_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (take) begin
            st_q  <= ST_CELL;
            ph_q  <= 1'b0;
            bit_q <= tx_data;
          end
        end
        ST_CELL: begin
          if (!ph_q) begin
            ph_q <= 1'b1;
          end else if (take) begin
            ph_q  <= 1'b0;
            bit_q <= tx_data;
          end else begin
            st_q  <= ST_TAIL;
            ph_q  <= 1'b0;
            cnt_q <= '0;
          end
        end
        ST_TAIL: begin
          if (cnt_q == CNT_LAST) st_q <= ST_IDLE;
          else                   cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    line_idle = (st_q == ST_IDLE);
    case (st_q)
      ST_CELL: line_lvl = ph_q ? bit_q : ~bit_q;
      default: line_lvl = LVL_HIGH;
    endcase
  end

  assign state_o = st_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/mle_drive.sv
module mle_drive (
  input  logic clk,
  input  logic rst,
  input  logic line_lvl,
  input  logic line_idle,
  input  logic idle_eq,
  input  logic loop_en,
  output logic tx_p,
  output logic tx_n,
  output logic enc_o
);
  logic hold_idle;
  assign hold_idle = line_idle || loop_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_o <= 1'b1;
      tx_p  <= ~idle_eq;
      tx_n  <= 1'b0;
    end else begin
      enc_o <= line_idle ? 1'b1 : line_lvl;
      if (hold_idle) begin
        tx_p <= ~idle_eq;
        tx_n <= 1'b0;
      end else begin
        tx_p <= line_lvl;
        tx_n <= ~line_lvl;
      end
    end
  end
endmodule

// File: rtl/mle_tx.sv
module mle_tx
  import mle_pkg::*;
#(
  parameter int TAIL_HALVES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_valid,
  input  logic tx_data,
  output logic tx_ready,
  input  logic idle_eq,
  input  logic loop_en,
  output logic tx_p,
  output logic tx_n,
  output logic enc_o
);
  logic       lvl_w;
  logic       idle_w;
  mle_state_e st_w;
  logic       ph_w;

  mle_seq #(.TAIL_HALVES(TAIL_HALVES)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .line_lvl (lvl_w),
    .line_idle(idle_w),
    .state_o  (st_w),
    .phase_o  (ph_w)
  );

  mle_drive u_drive (
    .clk      (clk),
    .rst      (rst),
    .line_lvl (lvl_w),
    .line_idle(idle_w),
    .idle_eq  (idle_eq),
    .loop_en  (loop_en),
    .tx_p     (tx_p),
    .tx_n     (tx_n),
    .enc_o    (enc_o)
  );
endmodule

// File: rtl/mle_tx_chk.sv
module mle_tx_chk
  import mle_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic       tx_data,
  input logic       tx_ready,
  input logic       idle_eq,
  input logic       loop_en,
  input logic       tx_p,
  input logic       tx_n,
  input logic       enc_o,
  input mle_state_e st,
  input logic       ph
);
  // R10
  no_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_p && tx_n));

  // R8
  loop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(loop_en) |-> (tx_p == !$past(idle_eq)) && !tx_n);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R3
  first_half_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tx_valid && tx_ready && !rst, 2) |-> enc_o == !$past(tx_data, 2));

  // R3
  second_half_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tx_valid && tx_ready && !rst, 3) |-> enc_o == $past(tx_data, 3));

  // R4
  close_high_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CELL && ph && !tx_valid) |=> ##1 enc_o);

  // R6
  idle_diff_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st == ST_IDLE) && !$past(loop_en) && !$past(idle_eq)) |-> tx_p && !tx_n);

  // R7
  idle_eq_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(st == ST_IDLE) && $past(idle_eq)) |-> !tx_p && !tx_n);
endmodule

bind mle_tx mle_tx_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .tx_valid(tx_valid),
  .tx_data (tx_data),
  .tx_ready(tx_ready),
  .idle_eq (idle_eq),
  .loop_en (loop_en),
  .tx_p    (tx_p),
  .tx_n    (tx_n),
  .enc_o   (enc_o),
  .st      (st_w),
  .ph      (ph_w)
);

// File: tb/mle_tx_tb.sv
`timescale 1ns/1ps
module mle_tx_tb_top;
  localparam int T = 2;
  localparam int LOGN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_valid = 1'b0;
  logic tx_data = 1'b0;
  logic tx_ready;
  logic idle_eq = 1'b0;
  logic loop_en = 1'b0;
  logic tx_p, tx_n, enc_o;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic lp [LOGN];
  logic ln [LOGN];
  logic le [LOGN];
  logic lr [LOGN];

  always #2.5 clk = ~clk;

  mle_tx #(.TAIL_HALVES(T)) dut_i (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .idle_eq(idle_eq), .loop_en(loop_en),
    .tx_p(tx_p), .tx_n(tx_n), .enc_o(enc_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lp[cyc % LOGN] <= tx_p;
    ln[cyc % LOGN] <= tx_n;
    le[cyc % LOGN] <= enc_o;
    lr[cyc % LOGN] <= tx_ready;
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Send n bits (bits[0] first); called at a negedge, returns at a negedge
  task automatic send(input logic [31:0] bits, input int n, output int hs);
    int i;
    logic took;
    bit first;
    i = 0; first = 1'b1; hs = -1;
    tx_valid = 1'b1; tx_data = bits[0];
    while (i < n) begin
      took = tx_ready;
      if (took && first) begin hs = cyc + 1; first = 1'b0; end
      @(negedge clk);
      if (took) begin
        i++;
        if (i < n) tx_data = bits[i];
      end
    end
    tx_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Compare the logged window of a frame taken first at edge hs
  task automatic check_frame(input string req, input logic [31:0] bits, input int n,
                             input int hs, input logic sel, input logic lb);
    int bad_line, bad_enc, bad_rdy, bad_short;
    logic [3:0] a_line, e_line, a_enc, e_enc, a_rdy, e_rdy;
    bad_line = 0; bad_enc = 0; bad_rdy = 0; bad_short = 0;
    a_line = 0; e_line = 0; a_enc = 0; e_enc = 0; a_rdy = 0; e_rdy = 0;
    while (cyc < hs + 2*n + T + 3) @(negedge clk);
    for (int j = 0; j <= 2*n + T; j++) begin
      int idx;
      logic lvl, idl, ep, en, er;
      idx = (hs + 1 + j) % LOGN;
      lvl = (j < 2*n) ? ((j % 2 == 0) ? ~bits[j/2] : bits[j/2]) : 1'b1;
      idl = (j >= 2*n + T);
      ep  = (idl || lb) ? ~sel : lvl;
      en  = (idl || lb) ? 1'b0 : ~lvl;
      if ({lp[idx], ln[idx]} !== {ep, en} && bad_line == 0) begin
        bad_line = 1; a_line = {2'b0, lp[idx], ln[idx]}; e_line = {2'b0, ep, en};
      end
      if (le[idx] !== lvl && bad_enc == 0) begin
        bad_enc = 1; a_enc = {3'b0, le[idx]}; e_enc = {3'b0, lvl};
      end
      if (lp[idx] && ln[idx]) bad_short = 1;
      idx = (hs + j) % LOGN;
      er = (j < 2*n) ? logic'(j % 2) : ((j < 2*n + T) ? 1'b0 : 1'b1);
      if (lr[idx] !== er && bad_rdy == 0) begin
        bad_rdy = 1; a_rdy = {3'b0, lr[idx]}; e_rdy = {3'b0, er};
      end
    end
    check({req, " R3 R4 R5 pair"}, a_line, e_line);
    check({req, " R9 enc_o"}, a_enc, e_enc);
    check({req, " R2 R5 ready"}, a_rdy, e_rdy);
    check({req, " R10 no both high"}, {3'b0, logic'(bad_short)}, 4'b0);
  endtask

  task automatic t_reset();
    check("R1 ready in reset", {3'b0, tx_ready}, 4'b1);
    check("R1 R6 idle pair/enc", {1'b0, tx_p, tx_n, enc_o}, 4'b0101);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); idle_eq = 1'b1;
    @(negedge clk);
    check("R7 equal idle", {2'b0, tx_p, tx_n}, 4'b0000);
    idle_eq = 1'b0;
    @(negedge clk);
    check("R6 driven idle", {2'b0, tx_p, tx_n}, 4'b0010);
  endtask

  task automatic t_end_one();
    int hs;
    send(32'b1101, 4, hs);
    check_frame("end-one", 32'b1101, 4, hs, 1'b0, 1'b0);
    // R4: last bit 1 -> low first half, high second half, stays high
    check("R4 final one mid-cell rise",
          {1'b0, le[(hs+7)%LOGN], le[(hs+8)%LOGN], le[(hs+9)%LOGN]}, 4'b0011);
  endtask

  task automatic t_end_zero();
    int hs;
    send(32'b0110, 4, hs);
    check_frame("end-zero", 32'b0110, 4, hs, 1'b0, 1'b0);
    // R4: last bit 0 -> high, low, then rise at the boundary
    check("R4 final zero boundary rise",
          {1'b0, lp[(hs+7)%LOGN], lp[(hs+8)%LOGN], lp[(hs+9)%LOGN]}, 4'b0101);
  endtask

  task automatic t_single();
    int hs;
    send(32'b0, 1, hs);
    check_frame("single zero", 32'b0, 1, hs, 1'b0, 1'b0);
    send(32'b1, 1, hs);
    check_frame("single one", 32'b1, 1, hs, 1'b0, 1'b0);
  endtask

  task automatic t_sel_eq();
    int hs;
    idle_eq = 1'b1;
    @(negedge clk);
    send(32'b010011, 6, hs);
    check_frame("R7 equal-idle frame", 32'b010011, 6, hs, 1'b1, 1'b0);
    idle_eq = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_loop();
    int hs;
    loop_en = 1'b1;
    @(negedge clk);
    send(32'b10110010, 8, hs);
    check_frame("R8 loopback", 32'b10110010, 8, hs, 1'b0, 1'b1);
    idle_eq = 1'b1;
    send(32'b011, 3, hs);
    check_frame("R8 loopback equal", 32'b011, 3, hs, 1'b1, 1'b1);
    loop_en = 1'b0; idle_eq = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_b2b();
    int h1, h2;
    send(32'b100, 3, h1);
    send(32'b11, 2, h2);
    // R11: last bit of first frame taken at h1+4
    check("R11 request waits for tail", h2[3:0] - h1[3:0], 4'(2*3 + T + 1));
    check_frame("R11 first frame", 32'b100, 3, h1, 1'b0, 1'b0);
    check_frame("R11 second frame", 32'b11, 2, h2, 1'b0, 1'b0);
  endtask

  task automatic t_long();
    int hs;
    send(32'hA5C3_0F69, 32, hs);
    check_frame("long pattern", 32'hA5C3_0F69, 32, hs, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_end_one();
    t_end_zero();
    t_single();
    t_sel_eq();
    t_loop();
    t_b2b();
    t_long();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule